// File: doc/BRIEF.md
# Read-Only Host Port to ISA I/O Bridge

This block lets a host that can only issue read cycles reach an 8-bit ISA-style I/O bus and a 16-bit wide peripheral. The host never drives data toward the block. A write is coded into the address of a read. Host address bit 16 chooses a window: 0 is the read window and 1 is the write window. Bits 13:9 give the register offset. Bits 8:1 carry the byte to write. A separate `host_wide` input steers the access to the 16-bit peripheral path instead of the byte-wide ISA path.

The block samples the host address on the rising edge of the host read strobe and turns it into one device strobe. On the narrow path that strobe is `isa_ior` or `isa_iow`, and it places the offset on the ISA address at I/O base 0x300. A narrow read returns the ISA byte on host data bits 15:8. A narrow write drives the address-carried byte onto the ISA data bus. A wide read returns all 16 bits of the wide peripheral and also keeps bits 8:1 of its address as a pending low byte. A later wide write-window access supplies the high byte and produces a single 16-bit write strobe.

Every device strobe stays high for `STROBE_CYC` clock cycles. Read data is captured in the last cycle of the strobe.

Top module: `ro_isa_bridge`

## Requirements
- R1: After reset, all four device strobes are low, `isa_data_oe` is low, `host_dout` is 0, `isa_addr` is 0x300, and no low byte is pending.
- R2: For every accepted access, `isa_addr` becomes 0x300 OR host address bits 13:9, taken on the rising edge of `host_rd`. A rejected access leaves `isa_addr` unchanged.
- R3: A narrow access with host address bit 16 at 0 raises `isa_ior` for exactly `STROBE_CYC` cycles. `host_dout` then becomes {`isa_data_i`, 8'h00}, sampled in the last strobe cycle.
- R4: A narrow access with host address bit 16 at 1 raises `isa_iow` for exactly `STROBE_CYC` cycles. `isa_data_oe` is high in exactly those cycles with `isa_data_o` equal to host address bits 8:1, and `host_dout` keeps its previous value.
- R5: A wide access with bit 16 at 0 raises `wide_rd` for exactly `STROBE_CYC` cycles. `host_dout` then becomes `wide_data_i`, sampled in the last strobe cycle, and host address bits 8:1 become the pending low byte.
- R6: A wide access with bit 16 at 1 while a low byte is pending raises `wide_wr` for exactly `STROBE_CYC` cycles with `wide_wdata` = {host address bits 8:1, pending low byte}. The pending byte is consumed by this access.
- R7: A wide write-window access with no pending low byte produces no strobe and leaves `host_dout` and `isa_addr` unchanged.
- R8: Narrow accesses neither set, change nor consume the pending low byte.
- R9: A rising edge of `host_rd` while a strobe is active is ignored, and holding `host_rd` high does not start a second access.
- R10: At most one of the four device strobes is high in any cycle, and `isa_data_oe` is never high while `isa_ior` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 17 | Host address; bit 16 selects the window |
| host_rd | input | 1 | Host read strobe, active high |
| host_wide | input | 1 | 1 selects the 16-bit peripheral path |
| host_dout | output | 16 | Data returned to the host |
| isa_addr | output | 10 | ISA I/O address |
| isa_ior | output | 1 | ISA read strobe |
| isa_iow | output | 1 | ISA write strobe |
| isa_data_i | input | 8 | ISA data from the device |
| isa_data_o | output | 8 | ISA data toward the device |
| isa_data_oe | output | 1 | ISA data driver enable |
| wide_rd | output | 1 | Wide peripheral read strobe |
| wide_wr | output | 1 | Wide peripheral write strobe |
| wide_data_i | input | 16 | Wide peripheral read data |
| wide_wdata | output | 16 | Wide peripheral write data |

## Verification
The pending low byte is the most fragile state. If it is lost, a completing write produces no `wide_wr` at all, which is visible within `STROBE_CYC` cycles of that access. If it is stale or leaks across a narrow access, the very next 16-bit write shows the wrong low half on `wide_wdata`. A wrong access kind or a wrong strobe count shows on the strobe pins and the `isa_data_oe` enable during the access itself. A late or early capture shows on `host_dout` once the strobe falls. The bench therefore counts strobe cycles per access, tracks the pending byte in its own model, and checks write data and returned data after every access.

// File: rtl/isab_pkg.sv
package isab_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ACC_NONE = 3'd0,
        ACC_NRD  = 3'd1,
        ACC_NWR  = 3'd2,
        ACC_WRD  = 3'd3,
        ACC_WWR  = 3'd4
    } acc_e;
endpackage

// File: rtl/isab_decode.sv
module isab_decode
    import isab_pkg::*;
#(
    parameter int HOST_AW = 17,
    parameter int WIN_BIT = 16,
    parameter int OFS_LO  = 9,
    parameter int OFS_W   = 5,
    parameter int DAT_LO  = 1
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic               wide,
    input  logic               hold_valid,
    output acc_e               kind,
    output logic [OFS_W-1:0]   ofs,
    output logic [BYTE_W-1:0]  dbyte
);
    logic win;

    always_comb begin
        win   = addr[WIN_BIT];
        ofs   = addr[OFS_LO +: OFS_W];
        dbyte = addr[DAT_LO +: BYTE_W];
        unique case ({wide, win})
            2'b00:   kind = ACC_NRD;
            2'b01:   kind = ACC_NWR;
            2'b10:   kind = ACC_WRD;
            default: kind = hold_valid ? ACC_WWR : ACC_NONE;
        endcase
    end
endmodule

// File: rtl/isab_timer.sv
module isab_timer #(
    parameter int STROBE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(STROBE_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tst_t;

    tst_t tq, td;

    always_comb begin
        td = tq;
        if (tq.busy) begin
            if (tq.cnt == '0) td.busy = 1'b0;
            else              td.cnt  = tq.cnt - 1'b1;
        end else if (start) begin
            td.busy = 1'b1;
            td.cnt  = CW'(STROBE_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tq <= '0;
        else        tq <= td;
    end

    assign busy = tq.busy;
    assign last = tq.busy && (tq.cnt == '0);

    // strobe length watcher: counts consecutive busy cycles
    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    a_r3_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CW+1)'(STROBE_CYC));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);
endmodule

// File: rtl/ro_isa_bridge.sv
module ro_isa_bridge
    import isab_pkg::*;
#(
    parameter int               HOST_AW    = 17,
    parameter int               WIN_BIT    = 16,
    parameter int               OFS_LO     = 9,
    parameter int               OFS_W      = 5,
    parameter int               DAT_LO     = 1,
    parameter int               ISA_AW     = 10,
    parameter logic [ISA_AW-1:0] IO_BASE   = 10'h300,
    parameter int               STROBE_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wide,
    output logic [15:0]        host_dout,
    output logic [ISA_AW-1:0]  isa_addr,
    output logic               isa_ior,
    output logic               isa_iow,
    input  logic [7:0]         isa_data_i,
    output logic [7:0]         isa_data_o,
    output logic               isa_data_oe,
    output logic               wide_rd,
    output logic               wide_wr,
    input  logic [15:0]        wide_data_i,
    output logic [15:0]        wide_wdata
);
    localparam int PAD_W = ISA_AW - OFS_W;

    typedef struct packed {
        logic               rd_prev;
        acc_e               kind;
        logic [OFS_W-1:0]   ofs;
        logic [BYTE_W-1:0]  wbyte;
        logic               drive;
        logic [BYTE_W-1:0]  hold;
        logic               hold_v;
        logic [WORD_W-1:0]  dout;
        logic [WORD_W-1:0]  wdata;
    } st_t;

    st_t q, d;

    acc_e              dec_kind;
    logic [OFS_W-1:0]  dec_ofs;
    logic [BYTE_W-1:0] dec_byte;
    logic              start, busy, last;

    isab_decode #(
        .HOST_AW (HOST_AW),
        .WIN_BIT (WIN_BIT),
        .OFS_LO  (OFS_LO),
        .OFS_W   (OFS_W),
        .DAT_LO  (DAT_LO)
    ) u_decode (
        .addr       (host_addr),
        .wide       (host_wide),
        .hold_valid (q.hold_v),
        .kind       (dec_kind),
        .ofs        (dec_ofs),
        .dbyte      (dec_byte)
    );

    isab_timer #(
        .STROBE_CYC (STROBE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .last  (last)
    );

    assign start = host_rd && !q.rd_prev && !busy && (dec_kind != ACC_NONE);

    always_comb begin
        d         = q;
        d.rd_prev = host_rd;
        if (start) begin
            d.kind  = dec_kind;
            d.ofs   = dec_ofs;
            d.wbyte = dec_byte;
            d.drive = (dec_kind == ACC_NWR);
            if (dec_kind == ACC_WRD) begin
                d.hold   = dec_byte;
                d.hold_v = 1'b1;
            end
            if (dec_kind == ACC_WWR) begin
                d.wdata  = {dec_byte, q.hold};
                d.hold_v = 1'b0;
            end
        end
        if (last) begin
            d.drive = 1'b0;
            unique case (q.kind)
                ACC_NRD: d.dout = {isa_data_i, 8'h00};
                ACC_WRD: d.dout = wide_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.kind <= ACC_NONE;
        end else begin
            q <= d;
        end
    end

    assign isa_ior     = busy && (q.kind == ACC_NRD);
    assign isa_iow     = busy && (q.kind == ACC_NWR);
    assign wide_rd     = busy && (q.kind == ACC_WRD);
    assign wide_wr     = busy && (q.kind == ACC_WWR);
    assign isa_data_o  = q.wbyte;
    assign isa_data_oe = q.drive;
    assign wide_wdata  = q.wdata;
    assign host_dout   = q.dout;
    assign isa_addr    = IO_BASE | {{PAD_W{1'b0}}, q.ofs};

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({isa_ior, isa_iow, wide_rd, wide_wr}));

    a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        isa_data_oe |-> (isa_iow && !isa_ior));

    a_r4_drive_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(isa_iow) |-> !isa_data_oe);

    a_r6_hold_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wide_wr) |-> (!q.hold_v && $past(q.hold_v)));

    a_r9_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> ($stable(q.kind) && $stable(q.ofs)));
endmodule

// File: tb/ro_isa_bridge_bench.sv
module ro_isa_bridge_bench;
    localparam int STRB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wide = 1'b0;
    logic [15:0] host_dout;
    logic [9:0]  isa_addr;
    logic        isa_ior, isa_iow, isa_data_oe, wide_rd, wide_wr;
    logic [7:0]  isa_data_i = '0;
    logic [7:0]  isa_data_o;
    logic [15:0] wide_data_i = '0;
    logic [15:0] wide_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic        m_hold_v = 1'b0;
    logic [7:0]  m_hold = '0;
    logic [15:0] m_dout = '0;
    logic [9:0]  m_isa = 10'h300;

    always #2 clk = ~clk;

    ro_isa_bridge #(.STROBE_CYC(STRB)) u_ro_isa_bridge (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wide(host_wide), .host_dout(host_dout), .isa_addr(isa_addr),
        .isa_ior(isa_ior), .isa_iow(isa_iow), .isa_data_i(isa_data_i),
        .isa_data_o(isa_data_o), .isa_data_oe(isa_data_oe), .wide_rd(wide_rd),
        .wide_wr(wide_wr), .wide_data_i(wide_data_i), .wide_wdata(wide_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    function automatic logic [9:0] f_isa(input logic [16:0] a);
        return 10'h300 | {5'd0, a[13:9]};
    endfunction

    function automatic logic [7:0] f_byte(input logic [16:0] a);
        return a[8:1];
    endfunction

    // one access; glitch=1 re-raises host_rd while the strobe is active (R9)
    task automatic do_acc(input logic [16:0] a, input logic w, input logic glitch);
        int c_ior = 0, c_iow = 0, c_wrd = 0, c_wwr = 0, c_oe = 0, c_bad = 0;
        logic [7:0]  seen_d = '0;
        logic [15:0] seen_w = '0;
        logic        win = a[16];
        logic        acc;
        logic [7:0]  in8;
        logic [15:0] in16;
        in8  = 8'($urandom);
        in16 = 16'($urandom);
        @(negedge clk);
        isa_data_i  = in8;
        wide_data_i = in16;
        host_addr   = a;
        host_wide   = w;
        host_rd     = 1'b1;
        for (int i = 0; i < STRB + 4; i++) begin
            @(negedge clk);
            if (isa_ior) c_ior++;
            if (isa_iow) c_iow++;
            if (wide_rd) c_wrd++;
            if (wide_wr) c_wwr++;
            if (isa_data_oe) begin c_oe++; seen_d = isa_data_o; end
            if (isa_data_oe && !isa_iow) c_bad++;
            if (isa_ior && isa_data_oe) c_bad++;
            if (wide_wr) seen_w = wide_wdata;
            if (glitch && i == 0) host_rd = 1'b0;
            if (glitch && i == 1) begin host_rd = 1'b1; host_addr = ~a; end
        end
        host_rd = 1'b0;
        @(negedge clk);
        acc = !(w && win && !m_hold_v);
        chk("R3 ior cycles", c_ior, (!w && !win) ? STRB : 0);
        chk("R4 iow cycles", c_iow, (!w && win) ? STRB : 0);
        chk("R5 wide_rd cycles", c_wrd, (w && !win) ? STRB : 0);
        chk("R6 R7 wide_wr cycles", c_wwr, (w && win && m_hold_v) ? STRB : 0);
        chk("R4 oe cycles", c_oe, (!w && win) ? STRB : 0);
        chk("R10 drive during read", c_bad, 0);
        if (!w && win) chk("R4 isa write byte", seen_d, f_byte(a));
        if (w && win && m_hold_v) begin
            chk("R6 wide write word", seen_w, {f_byte(a), m_hold});
            m_hold_v = 1'b0;
        end
        if (w && !win) begin
            m_dout   = in16;
            m_hold   = f_byte(a);
            m_hold_v = 1'b1;
        end
        if (!w && !win) m_dout = {in8, 8'h00};
        if (acc) m_isa = f_isa(a);
        chk("R2 isa address", isa_addr, m_isa);
        chk("R3 R5 R7 host data", host_dout, m_dout);
    endtask

    function automatic logic [16:0] mk(input logic win);
        logic [16:0] a;
        a = 17'($urandom);
        a[16] = win;
        return a;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobes", {isa_ior, isa_iow, wide_rd, wide_wr, isa_data_oe}, 0);
        chk("R1 host data", host_dout, 16'h0);
        chk("R1 isa address", isa_addr, 10'h300);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: nothing pending after reset
        do_acc(mk(1'b1), 1'b1, 1'b0);
        // directed: R5 latch, R8 narrow accesses between, R6 complete
        do_acc({1'b0, 5'h1f, 2'b00, 8'hA5, 1'b0}, 1'b1, 1'b0);
        do_acc(mk(1'b0), 1'b0, 1'b0);
        do_acc(mk(1'b1), 1'b0, 1'b0);
        do_acc({1'b1, 5'h00, 2'b00, 8'h3C, 1'b0}, 1'b1, 1'b0);
        // R7: second completion finds nothing pending
        do_acc(mk(1'b1), 1'b1, 1'b0);
        // R9: re-raised strobe during access is ignored
        do_acc(mk(1'b0), 1'b0, 1'b1);
        do_acc(mk(1'b1), 1'b0, 1'b1);
        // R1: reset clears a pending low byte
        do_acc(mk(1'b0), 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        m_hold_v = 1'b0; m_dout = '0; m_isa = 10'h300;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        chk("R1 host data after reset", host_dout, 16'h0);
        do_acc(mk(1'b1), 1'b1, 1'b0);
        // random mix
        for (int k = 0; k < 120; k++) begin
            do_acc(mk(1'($urandom)), 1'($urandom), ($urandom % 8) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, R1-chain stalled: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule